// File: doc/BRIEF.md
# Bus-Stepped Wiper Position Counter

This block holds the position of one potentiometer wiper as a 6-bit count and turns that count into a one-hot select over 64 tap switches. Position 0 drives the switch at the low end of the resistor string. The highest position drives the switch at the high end.

The instruction controller sets the count in one of two ways. It can write a value straight in, or it can copy in the contents of a data register. After power-up it pulses a separate strobe, which copies in the content of data register zero.

The controller can also put the block into a stepping mode. While that mode is on, the block watches the two serial bus lines itself. Each clock-line high pulse moves the wiper by one tap. The direction comes from the level of the data line during that pulse. The count stops at either end of the range. Any start or stop condition on the bus ends the stepping mode.

The bus line levels arrive already synchronised to the system clock `clk`. Each bus event lasts several system clock cycles.

Top module: `wiper_step_counter`

## Requirements
- R1: During and after synchronous reset (`rst_n` low), `wiper_pos` is 0, `tap_sel` has only bit 0 set, and `step_mode` is 0.
- R2: `tap_sel` always has exactly one bit set. Its set bit index equals the value `wiper_pos` held one clock earlier.
- R3: A cycle with `wr_valid` high sets `wiper_pos` to `wr_value` on the next clock edge.
- R4: A cycle with `init_load` high sets `wiper_pos` to `init_value` on the next clock edge. It wins over `wr_valid` in the same cycle.
- R5: When a write or init load falls in the same cycle as a step, the loaded value is taken and the step is dropped.
- R6: While `step_mode` is 0, clock-line pulses leave `wiper_pos` unchanged. A one-cycle pulse on `step_arm` sets `step_mode` to 1.
- R7: In stepping mode, a `bus_scl` high pulse with `bus_sda` high at its rising edge adds 1 to `wiper_pos`. The change takes effect on the clock edge that sees `bus_scl` fall.
- R8: In stepping mode, a `bus_scl` high pulse with `bus_sda` low at its rising edge subtracts 1 from `wiper_pos`. The timing is the same as in R7.
- R9: A step up at 63 leaves `wiper_pos` at 63. A step down at 0 leaves it at 0.
- R10: A start condition (`bus_sda` falling while `bus_scl` is high) or a stop condition (`bus_sda` rising while `bus_scl` is high) clears `step_mode`. The clock pulse that carried it takes no step.
- R11: Stepping mode stays on across any number of pulses and across direct writes, until a start or stop condition clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_scl | input | 1 | Synchronised serial clock line level |
| bus_sda | input | 1 | Synchronised serial data line level |
| step_arm | input | 1 | One-cycle pulse that enables stepping mode |
| wr_valid | input | 1 | Direct write or register transfer strobe |
| wr_value | input | 6 | Value for a direct write or transfer |
| init_load | input | 1 | Power-up load strobe |
| init_value | input | 6 | Content of data register zero |
| wiper_pos | output | 6 | Current wiper count |
| tap_sel | output | 64 | One-hot tap switch enables, bit 0 at the low terminal |
| step_mode | output | 1 | Stepping mode is active |

## Verification
The bench drives the count into both ends and keeps pulsing. A counter that wraps would show 0 after 63, or 63 after 0.

It ends stepping mode with a start condition and with a stop condition, each in the middle of a clock pulse whose rising edge had already been seen. A design that still took that step would move the wiper by one.

It also lines up a clock-line fall with a direct write in the same cycle. It loads the init value and a write together as well. A wrong priority would leave the wiper one tap off, or at the written value instead of the init value.

Right after a load, it checks that `tap_sel` still shows the old position for exactly one cycle. This catches a decoder that is made combinational or delayed by two registers.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    // Width of the wiper count; the tap count follows from it
    localparam int unsigned WIPER_W = 6;
    localparam int unsigned TAP_N   = 1 << WIPER_W;

    // Decoded bus activity for one system clock cycle
    typedef struct packed {
        logic rise;   // clock line went high
        logic fall;   // clock line went low
        logic start;  // data fell while clock high
        logic stop;   // data rose while clock high
    } bus_evt_t;
endpackage

// File: rtl/bus_edge_detect.sv
// Detects clock-line edges and start/stop conditions on the bus lines.
// Assumes both lines are already synchronised to clk and held for
// several cycles per bus event. Idle level after reset is high on both.
module bus_edge_detect
    import wiper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Classify the change between the previous and the current sample
    always_comb begin
        evt.rise  = !scl_q && scl;
        evt.fall  = scl_q && !scl;
        evt.start = scl_q && scl && sda_q && !sda;
        evt.stop  = scl_q && scl && !sda_q && sda;
    end
endmodule

// File: rtl/step_control.sv
// Holds the stepping-mode flag and turns clock-line pulses into step
// requests. Direction is latched at the rising edge of the clock line.
// The step is issued at the falling edge, so a start or stop seen while
// the line is high cancels the pending step.
module step_control
    import wiper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     arm,
    input  bus_evt_t evt,
    input  logic     sda,
    output logic     mode,
    output logic     step_up,
    output logic     step_dn
);
    logic pend;
    logic dir_up;
    logic bus_cond;

    assign bus_cond = evt.start || evt.stop;

    // Mode flag: a bus condition ends it, an arm pulse starts it
    always_ff @(posedge clk) begin
        if (!rst_n)        mode <= 1'b0;
        else if (bus_cond) mode <= 1'b0;
        else if (arm)      mode <= 1'b1;
    end

    // Pending pulse and its direction, captured at the rising clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            dir_up <= 1'b0;
        end else if (bus_cond || evt.fall) begin
            pend   <= 1'b0;
        end else if (evt.rise && mode) begin
            pend   <= 1'b1;
            dir_up <= sda;
        end
    end

    // Issue one step when a pending pulse completes
    always_comb begin
        step_up = evt.fall && pend && mode && dir_up;
        step_dn = evt.fall && pend && mode && !dir_up;
    end
endmodule

// File: rtl/wiper_count.sv
// Saturating up/down wiper counter with two load sources.
// Priority: init load, then write, then step.
module wiper_count #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_load,
    input  logic [W-1:0] init_value,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_value,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Update the count with load priority and end-stop saturation
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (init_load)                count <= init_value;
        else if (wr_valid)                 count <= wr_value;
        else if (step_up && count != TOP)  count <= count + 1'b1;
        else if (step_dn && count != '0)   count <= count - 1'b1;
    end
endmodule

// File: rtl/tap_decoder.sv
// Registered binary-to-one-hot decoder driving the tap switches.
// Output lags the count by one clock; reset selects the low-end tap.
module tap_decoder #(
    parameter int unsigned W = 6,
    localparam int unsigned N = 1 << W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    output logic [N-1:0] sel
);
    for (genvar i = 0; i < N; i++) begin : g_tap
        // One register per tap switch enable
        always_ff @(posedge clk) begin
            if (!rst_n) sel[i] <= (i == 0);
            else        sel[i] <= (count == W'(i));
        end
    end
endmodule

// File: rtl/wiper_step_counter.sv
// Top of one wiper channel: bus event detection, stepping control,
// saturating counter and registered tap decode. Assumes the bus lines
// are synchronised and that load strobes come from the instruction
// controller as single-cycle pulses.
module wiper_step_counter
    import wiper_pkg::*;
#(
    parameter int unsigned W = WIPER_W,
    localparam int unsigned N = 1 << W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_scl,
    input  logic         bus_sda,
    input  logic         step_arm,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_value,
    input  logic         init_load,
    input  logic [W-1:0] init_value,
    output logic [W-1:0] wiper_pos,
    output logic [N-1:0] tap_sel,
    output logic         step_mode
);
    bus_evt_t evt;
    logic     step_up;
    logic     step_dn;

    bus_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (bus_scl),
        .sda   (bus_sda),
        .evt   (evt)
    );

    step_control u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (step_arm),
        .evt     (evt),
        .sda     (bus_sda),
        .mode    (step_mode),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    wiper_count #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_load  (init_load),
        .init_value (init_value),
        .wr_valid   (wr_valid),
        .wr_value   (wr_value),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .count      (wiper_pos)
    );

    tap_decoder #(.W(W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .count (wiper_pos),
        .sel   (tap_sel)
    );
endmodule

// File: rtl/wiper_step_counter_chk.sv
// Property checker for wiper_step_counter, attached by bind below.
module wiper_step_counter_chk #(
    parameter int unsigned W = 6,
    localparam int unsigned N = 1 << W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] wiper_pos,
    input logic [N-1:0] tap_sel,
    input logic         step_mode,
    input logic         wr_valid,
    input logic [W-1:0] wr_value,
    input logic         init_load,
    input logic [W-1:0] init_value,
    input logic         step_up,
    input logic         step_dn,
    input logic         cond_seen
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic no_load;
    assign no_load = !wr_valid && !init_load;

    a_r2_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);
    a_r2_tap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_sel == (N'(1) << $past(wiper_pos)));
    a_r3_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !init_load |=> wiper_pos == $past(wr_value));
    a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> wiper_pos == $past(init_value));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_mode && no_load |=> $stable(wiper_pos));
    a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        step_up && no_load && wiper_pos != TOP |=> wiper_pos == $past(wiper_pos) + 1'b1);
    a_r8_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn && no_load && wiper_pos != '0 |=> wiper_pos == $past(wiper_pos) - 1'b1);
    a_r9_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        step_up && no_load && wiper_pos == TOP |=> wiper_pos == TOP);
    a_r9_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn && no_load && wiper_pos == '0 |=> wiper_pos == '0);
    a_r10_mode_end: assert property (@(posedge clk) disable iff (!rst_n)
        cond_seen |=> !step_mode);
endmodule

bind wiper_step_counter wiper_step_counter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wiper_pos  (wiper_pos),
    .tap_sel    (tap_sel),
    .step_mode  (step_mode),
    .wr_valid   (wr_valid),
    .wr_value   (wr_value),
    .init_load  (init_load),
    .init_value (init_value),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .cond_seen  (evt.start || evt.stop)
);

// File: tb/tb_wiper_step_counter.sv
module tb_wiper_step_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_scl = 1'b1;
    logic        bus_sda = 1'b1;
    logic        step_arm = 1'b0;
    logic        wr_valid = 1'b0;
    logic [5:0]  wr_value = '0;
    logic        init_load = 1'b0;
    logic [5:0]  init_value = '0;
    logic [5:0]  wiper_pos;
    logic [63:0] tap_sel;
    logic        step_mode;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] pos;
        logic       mode;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    wiper_step_counter dut (
        .clk(clk), .rst_n(rst_n), .bus_scl(bus_scl), .bus_sda(bus_sda),
        .step_arm(step_arm), .wr_valid(wr_valid), .wr_value(wr_value),
        .init_load(init_load), .init_value(init_value),
        .wiper_pos(wiper_pos), .tap_sel(tap_sel), .step_mode(step_mode)
    );

    // Advance to just after the next rising edge
    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Push an expected state; the monitor compares it at the next falling edge
    task automatic expect_state(logic [5:0] pos, logic mode, string tag);
        exp_t e;
        tick(2);
        e.pos = pos;
        e.mode = mode;
        e.tag = tag;
        sb.push_back(e);
        tick(1);
    endtask

    task automatic bus(logic c, logic d);
        bus_scl = c;
        bus_sda = d;
        tick(2);
    endtask

    // One full clock-line pulse with the data line at level d
    task automatic pulse(logic d);
        bus(1'b0, d);
        bus(1'b1, d);
        bus(1'b0, d);
    endtask

    task automatic write(logic [5:0] v);
        wr_valid = 1'b1;
        wr_value = v;
        tick(1);
        wr_valid = 1'b0;
    endtask

    task automatic arm();
        step_arm = 1'b1;
        tick(1);
        step_arm = 1'b0;
    endtask

    task automatic direct_check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (wiper_pos !== e.pos || step_mode !== e.mode ||
                tap_sel !== (64'h1 << e.pos)) begin
                bad++;
                $display("FAIL %s: actual pos=%0d mode=%b tap=%h expected pos=%0d mode=%b tap=%h",
                         e.tag, wiper_pos, step_mode, tap_sel, e.pos, e.mode, 64'h1 << e.pos);
            end
        end
    end

    initial begin
        #2;
        tick(3);
        expect_state(6'd0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        expect_state(6'd0, 1'b0, "R1 after reset");

        init_value = 6'd37; init_load = 1'b1; tick(1); init_load = 1'b0;
        expect_state(6'd37, 1'b0, "R4 init load");

        init_value = 6'd20; init_load = 1'b1; wr_valid = 1'b1; wr_value = 6'd9;
        tick(1); init_load = 1'b0; wr_valid = 1'b0;
        expect_state(6'd20, 1'b0, "R4 init over write");

        // R2: the value changes one edge before the tap select
        wr_valid = 1'b1; wr_value = 6'd12;
        @(posedge clk); #2;
        wr_valid = 1'b0;
        direct_check(wiper_pos == 6'd12 && tap_sel == (64'h1 << 20), "R2 tap lags count",
                     tap_sel, 64'h1 << 20);
        tick(1);
        direct_check(tap_sel == (64'h1 << 12), "R2 tap updated", tap_sel, 64'h1 << 12);
        expect_state(6'd12, 1'b0, "R3 write");

        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        expect_state(6'd12, 1'b0, "R6 pulses ignored without mode");

        arm();
        expect_state(6'd12, 1'b1, "R6 arm");
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        expect_state(6'd15, 1'b1, "R7 three up steps");
        pulse(1'b0); pulse(1'b0);
        expect_state(6'd13, 1'b1, "R8 two down steps");

        write(6'd62);
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        expect_state(6'd63, 1'b1, "R9 saturate at top, R11 mode kept across write");
        write(6'd1);
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        expect_state(6'd0, 1'b1, "R9 saturate at bottom");

        // R5: step and write land in the same cycle
        write(6'd30);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus_scl = 1'b0; wr_valid = 1'b1; wr_value = 6'd40;
        tick(1); wr_valid = 1'b0; tick(1);
        expect_state(6'd40, 1'b1, "R5 write beats step");

        // R10: stop condition inside a down pulse
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
        expect_state(6'd40, 1'b0, "R10 stop ends mode");
        bus(1'b0, 1'b1);
        pulse(1'b1);
        expect_state(6'd40, 1'b0, "R10 no step after stop");

        // R10: start condition inside an up pulse
        arm();
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        expect_state(6'd40, 1'b0, "R10 start ends mode without step");

        arm();
        bus(1'b0, 1'b1);
        pulse(1'b1);
        expect_state(6'd41, 1'b1, "R11 rearm steps again");

        tick(3);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule